// File: doc/BRIEF.md
# PWM Ramp Interrupt Generator

This block runs alongside a free-running PWM ramp counter and produces interrupt pulses at chosen points of each switching period. It watches the ramp count, the programmed period length and a half-mode flag. It also takes two edge strobes from the modulator and a rectified-voltage level that is not synchronised to the clock.

There are two interrupt sources. Source A fires either on the first modulation edge strobe or when the ramp reaches a programmable fraction of its span, in sixteenths. Source B fires either on the second modulation edge strobe or on a falling edge of the rectified-voltage input. One shared power-of-two divider thins out both sources, so that they fire only in every 2^N-th switching period. All configuration arrives as plain input ports.

Top module: `ramp_irq_gen`

## Requirements
- R1: With `a_sel_phase`=0, an event is raised on source A in every cycle where `t1_strobe`=1. `irq_a` is high in the cycle after that event.
- R2: With `a_sel_phase`=1, source A's compare value is (M × `phase_sel`) >> 4, where M is the maximum count. The event is raised in the first cycle of a period in which `ramp_cnt` ≥ that value, and `irq_a` is high in the following cycle.
- R3: M is `period_len` >> 1 when `half_mode`=1, and `period_len` otherwise.
- R4: With `b_sel_vrect`=0, an event is raised on source B in every cycle where `t2_strobe`=1. `irq_b` is high in the following cycle.
- R5: With `b_sel_vrect`=1, `vrect_in` passes through two synchronising flops, and a 1→0 change of the synchronised value is a source B event. A fall driven before a clock edge shows on `irq_b` after the third following edge. A rising change raises nothing.
- R6: A new switching period begins in each cycle where `ramp_cnt` is below its value in the previous cycle. A 6-bit period index starts at 0 after reset and increments at each such cycle. For rate codes 0 to 5 (N = code), events pass only in periods whose index has its low N bits equal to zero.
- R7: Rate codes 6 and 7 both give N = 6, which passes one period in 64.
- R8: The same rate code and period index gate both sources.
- R9: When `a_en`=0, `irq_a` stays low, and when `b_en`=0, `irq_b` stays low.
- R10: Each source passes at most one event per switching period. Every output pulse lasts a single clock.
- R11: While `rst` is high at a clock edge, the period index, the edge detector and both outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ramp_cnt | input | CNT_W | Current ramp count |
| period_len | input | CNT_W | Switching period length in counts |
| half_mode | input | 1 | Ramp spans half the period |
| t1_strobe | input | 1 | First modulation edge strobe |
| t2_strobe | input | 1 | Second modulation edge strobe |
| vrect_in | input | 1 | Rectified-voltage level, asynchronous |
| a_en | input | 1 | Source A enable |
| a_sel_phase | input | 1 | Source A: 0 = t1 strobe, 1 = phase point |
| b_en | input | 1 | Source B enable |
| b_sel_vrect | input | 1 | Source B: 0 = t2 strobe, 1 = vrect falling edge |
| phase_sel | input | 4 | Phase point in sixteenths of the ramp |
| rate_code | input | 3 | Period divider code |
| irq_a | output | 1 | Source A interrupt pulse |
| irq_b | output | 1 | Source B interrupt pulse |

## Verification
Some rules are checked by assertions on every cycle. A disabled source stays silent, a strobe-mode source stays silent in the cycle after a missing strobe, and reset clears both outputs. The bench's scenarios are needed for the rest. These are the phase compare value in full and half mode, the rate decimation including the aliasing of codes 6 and 7, the latency of the rectified-voltage edge, and the rule of one pulse per period. They are checked against a cycle model in the bench and against pulse counts over whole multiples of the divider period.

// File: rtl/rig_pkg.sv
`timescale 1ns/1ps
package rig_pkg;
    localparam int PHASE_W = 4;
    localparam int RATE_W  = 3;
    localparam int MAX_LOG = 6;
    localparam int PER_W   = MAX_LOG;

    // codes above MAX_LOG alias to MAX_LOG
    function automatic logic [RATE_W-1:0] rate_log(input logic [RATE_W-1:0] code);
        if (code >= RATE_W'(MAX_LOG)) return RATE_W'(MAX_LOG);
        return code;
    endfunction

    typedef struct packed {
        logic done_a;
        logic done_b;
        logic irq_a;
        logic irq_b;
    } irq_state_t;
endpackage

// File: rtl/rig_rate_gate.sv
`timescale 1ns/1ps
module rig_rate_gate
    import rig_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    ramp_cnt,
    input  logic [RATE_W-1:0]   rate_code,
    output logic                wrap,
    output logic                gate_open
);
    typedef struct packed {
        logic [CNT_W-1:0] prev;
        logic [PER_W-1:0] per;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic [PER_W-1:0]  idx;
    logic [PER_W-1:0]  mask;
    logic [PER_W:0]    span;
    logic [RATE_W-1:0] n_log;

    always_comb begin
        wrap      = (ramp_cnt < st_q.prev);
        idx       = st_q.per + PER_W'(wrap);
        n_log     = rate_log(rate_code);
        span      = (PER_W+1)'(1) << n_log;
        mask      = PER_W'(span - (PER_W+1)'(1));
        gate_open = ((idx & mask) == '0);
        st_d.prev = ramp_cnt;
        st_d.per  = idx;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/rig_phase_cmp.sv
`timescale 1ns/1ps
module rig_phase_cmp
    import rig_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]   ramp_cnt,
    input  logic [CNT_W-1:0]   period_len,
    input  logic               half_mode,
    input  logic [PHASE_W-1:0] phase_sel,
    output logic               reached
);
    localparam int PROD_W = CNT_W + PHASE_W;

    logic [CNT_W-1:0]  max_cnt;
    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  cmp_val;

    always_comb begin
        max_cnt = half_mode ? (period_len >> 1) : period_len;
        prod    = PROD_W'(max_cnt) * PROD_W'(phase_sel);
        cmp_val = CNT_W'(prod >> PHASE_W);
        reached = (ramp_cnt >= cmp_val);
    end
endmodule

// File: rtl/rig_rect_edge.sv
`timescale 1ns/1ps
module rig_rect_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vrect_in,
    output logic fall
);
    // stages 0..SYNC_STAGES-1 synchronise, last stage holds previous value
    logic [SYNC_STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SYNC_STAGES-1:0], vrect_in};
        fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end
endmodule

// File: rtl/ramp_irq_gen.sv
`timescale 1ns/1ps
module ramp_irq_gen
    import rig_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   ramp_cnt,
    input  logic [CNT_W-1:0]   period_len,
    input  logic               half_mode,
    input  logic               t1_strobe,
    input  logic               t2_strobe,
    input  logic               vrect_in,
    input  logic               a_en,
    input  logic               a_sel_phase,
    input  logic               b_en,
    input  logic               b_sel_vrect,
    input  logic [3:0]         phase_sel,
    input  logic [2:0]         rate_code,
    output logic               irq_a,
    output logic               irq_b
);
    logic wrap, gate_open, reached, fall;
    logic raw_a, raw_b, done_a, done_b;
    irq_state_t st_d, st_q;

    rig_rate_gate #(.CNT_W(CNT_W)) i_gate (
        .clk       (clk),
        .rst       (rst),
        .ramp_cnt  (ramp_cnt),
        .rate_code (rate_code),
        .wrap      (wrap),
        .gate_open (gate_open)
    );

    rig_phase_cmp #(.CNT_W(CNT_W)) i_phase (
        .ramp_cnt   (ramp_cnt),
        .period_len (period_len),
        .half_mode  (half_mode),
        .phase_sel  (phase_sel),
        .reached    (reached)
    );

    rig_rect_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk      (clk),
        .rst      (rst),
        .vrect_in (vrect_in),
        .fall     (fall)
    );

    always_comb begin
        raw_a       = a_sel_phase ? reached : t1_strobe;
        raw_b       = b_sel_vrect ? fall    : t2_strobe;
        // a new period forgets the previous period's event
        done_a      = st_q.done_a & ~wrap;
        done_b      = st_q.done_b & ~wrap;
        st_d.irq_a  = a_en & raw_a & ~done_a & gate_open;
        st_d.irq_b  = b_en & raw_b & ~done_b & gate_open;
        st_d.done_a = done_a | raw_a;
        st_d.done_b = done_b | raw_b;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign irq_a = st_q.irq_a;
    assign irq_b = st_q.irq_b;
endmodule

// File: rtl/rig_checker.sv
`timescale 1ns/1ps
module rig_checker (
    input logic clk,
    input logic rst,
    input logic a_en,
    input logic b_en,
    input logic a_sel_phase,
    input logic b_sel_vrect,
    input logic t1_strobe,
    input logic t2_strobe,
    input logic irq_a,
    input logic irq_b
);
    // R9
    a_r9_a_silent: assert property (@(posedge clk) disable iff (rst)
        !a_en |=> !irq_a);
    // R9
    a_r9_b_silent: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> !irq_b);
    // R1
    a_r1_needs_t1: assert property (@(posedge clk) disable iff (rst)
        (!a_sel_phase && !t1_strobe) |=> !irq_a);
    // R4
    a_r4_needs_t2: assert property (@(posedge clk) disable iff (rst)
        (!b_sel_vrect && !t2_strobe) |=> !irq_b);
    // R11
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq_a && !irq_b));
endmodule

bind ramp_irq_gen rig_checker i_rig_checker (
    .clk         (clk),
    .rst         (rst),
    .a_en        (a_en),
    .b_en        (b_en),
    .a_sel_phase (a_sel_phase),
    .b_sel_vrect (b_sel_vrect),
    .t1_strobe   (t1_strobe),
    .t2_strobe   (t2_strobe),
    .irq_a       (irq_a),
    .irq_b       (irq_b)
);

// File: tb/test_ramp_irq_gen.sv
`timescale 1ns/1ps
module test_ramp_irq_gen;
    localparam int CNT_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0] ramp_cnt = '0;
    logic [CNT_W-1:0] period_len = CNT_W'(20);
    logic half_mode = 1'b0, t1_strobe = 1'b0, t2_strobe = 1'b0, vrect_in = 1'b1;
    logic a_en = 1'b0, a_sel_phase = 1'b0, b_en = 1'b0, b_sel_vrect = 1'b0;
    logic [3:0] phase_sel = '0;
    logic [2:0] rate_code = '0;
    logic irq_a, irq_b;

    ramp_irq_gen #(.CNT_W(CNT_W)) i_ramp_irq_gen (.*);

    always #5 clk = ~clk;

    int vectors = 0, miscompares = 0;
    int t1_pos = 5, t2_pos = 12;
    int cnt_a, cnt_b, ramp_at_a, ramp_at_b;
    logic vr_next = 1'b1, wrap_req = 1'b0;
    logic exp_a = 1'b0, exp_b = 1'b0;

    // reference state
    int m_prev, m_per;
    logic m_da, m_db, m_s1, m_s2, m_s3;

    function automatic int max_of(int plen, logic half);
        return half ? (plen >> 1) : plen;
    endfunction
    function automatic int cmp_of(int plen, logic half, int ph);
        return (max_of(plen, half) * ph) >> 4;
    endfunction
    function automatic logic passes(int idx, int code);
        int n = (code >= 6) ? 6 : code;
        return (idx % (1 << n)) == 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_prev = 0; m_per = 0; m_da = 0; m_db = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; exp_a = 0; exp_b = 0;
        end else begin
            logic w, g, ra, rb, da, db;
            int idx;
            w   = int'(ramp_cnt) < m_prev;
            idx = (m_per + (w ? 1 : 0)) % 64;
            g   = passes(idx, int'(rate_code));
            ra  = a_sel_phase ? (int'(ramp_cnt) >= cmp_of(int'(period_len), half_mode, int'(phase_sel)))
                              : t1_strobe;
            rb  = b_sel_vrect ? (m_s3 & ~m_s2) : t2_strobe;
            da  = w ? 1'b0 : m_da;
            db  = w ? 1'b0 : m_db;
            exp_a = a_en & ra & ~da & g;
            exp_b = b_en & rb & ~db & g;
            m_da = da | ra; m_db = db | rb;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = vrect_in;
            m_per = idx; m_prev = int'(ramp_cnt);
        end
    end

    task automatic step();
        @(negedge clk);
        vectors++;
        if (irq_a !== exp_a) begin
            miscompares++;
            $display("FAIL %s irq_a actual %0b expected %0b ramp %0d",
                     a_sel_phase ? "R2" : "R1", irq_a, exp_a, ramp_cnt);
        end
        if (irq_b !== exp_b) begin
            miscompares++;
            $display("FAIL %s irq_b actual %0b expected %0b ramp %0d",
                     b_sel_vrect ? "R5" : "R4", irq_b, exp_b, ramp_cnt);
        end
        if (irq_a === 1'b1) begin cnt_a++; ramp_at_a = int'(ramp_cnt); end
        if (irq_b === 1'b1) begin cnt_b++; ramp_at_b = int'(ramp_cnt); end
        if (wrap_req || int'(ramp_cnt) >= max_of(int'(period_len), half_mode)) ramp_cnt = '0;
        else ramp_cnt = ramp_cnt + 1'b1;
        wrap_req  = 1'b0;
        t1_strobe = (int'(ramp_cnt) == t1_pos);
        t2_strobe = (int'(ramp_cnt) == t2_pos);
        vrect_in  = vr_next;
    endtask

    task automatic check(string req, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic align();
        while (int'(ramp_cnt) != max_of(int'(period_len), half_mode)) step();
    endtask

    task automatic run_periods(int n);
        cnt_a = 0; cnt_b = 0; ramp_at_a = -1; ramp_at_b = -1;
        repeat (n * (max_of(int'(period_len), half_mode) + 1)) step();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        // R11: reset state
        repeat (3) step();
        check("R11 irq_a in reset", int'(irq_a), 0);
        check("R11 irq_b in reset", int'(irq_b), 0);
        a_en = 1; b_en = 1;
        repeat (2) step();
        rst = 0;
        align();

        // R1: t1 every period
        run_periods(6);
        check("R1 t1 pulses", cnt_a, 6);
        check("R1 t1 position", ramp_at_a, t1_pos);
        // R4: t2 every period
        check("R4 t2 pulses", cnt_b, 6);
        check("R4 t2 position", ramp_at_b, t2_pos);

        // R9: disables
        a_en = 0; b_en = 0;
        run_periods(4);
        check("R9 a disabled", cnt_a, 0);
        check("R9 b disabled", cnt_b, 0);
        a_en = 1; b_en = 1;

        // R6: rate codes
        rate_code = 3'd2; run_periods(8);
        check("R6 rate 2", cnt_a, 2);
        rate_code = 3'd5; run_periods(64);
        check("R6 rate 5", cnt_a, 2);
        // R8: shared gate
        check("R8 b follows shared rate", cnt_b, 2);
        // R7: codes 6 and 7 alias
        rate_code = 3'd6; run_periods(128);
        check("R7 rate 6", cnt_a, 2);
        rate_code = 3'd7; run_periods(128);
        check("R7 rate 7", cnt_a, 2);
        check("R8 b on rate 7", cnt_b, 2);
        rate_code = 3'd0;

        // R2: phase point, full span 20 -> cmp 10
        a_sel_phase = 1; phase_sel = 4'd8;
        run_periods(6);
        check("R2 phase position", ramp_at_a, 10);
        check("R10 one pulse per period", cnt_a, 6);
        phase_sel = 4'd15; run_periods(1);
        check("R2 phase 15 position", ramp_at_a, 18);
        phase_sel = 4'd0; run_periods(1);
        check("R2 phase 0 position", ramp_at_a, 0);

        // R3: half mode halves the span -> cmp 5
        phase_sel = 4'd8; half_mode = 1; wrap_req = 1;
        run_periods(3);
        check("R3 half-mode phase position", ramp_at_a, 5);
        half_mode = 0; wrap_req = 1;
        run_periods(1);
        align();

        // R5: vrect falls at ramp 0, rises at 4, falls at 8
        b_sel_vrect = 1; vr_next = 1; run_periods(1);
        cnt_b = 0; ramp_at_b = -1;
        for (int i = 0; i <= 20; i++) begin
            vr_next = (i >= 4 && i < 8) ? 1'b1 : 1'b0;
            step();
        end
        check("R5 fall latency", ramp_at_b, 2);
        check("R10 two falls give one pulse", cnt_b, 1);
        cnt_b = 0;
        for (int i = 0; i <= 20; i++) begin
            vr_next = (i >= 5) ? 1'b1 : 1'b0;
            step();
        end
        check("R5 rising edge ignored", cnt_b, 0);

        // random periods against the cycle model
        for (int p = 0; p < 60; p++) begin
            period_len  = CNT_W'(8 + $urandom_range(0, 32));
            half_mode   = 1'($urandom_range(0, 1));
            phase_sel   = 4'($urandom_range(0, 15));
            rate_code   = 3'($urandom_range(0, 7) % 3);
            a_en        = 1'($urandom_range(0, 3) != 0);
            b_en        = 1'($urandom_range(0, 3) != 0);
            a_sel_phase = 1'($urandom_range(0, 1));
            b_sel_vrect = 1'($urandom_range(0, 1));
            t1_pos      = $urandom_range(0, max_of(int'(period_len), half_mode) - 1);
            t2_pos      = $urandom_range(0, max_of(int'(period_len), half_mode) - 1);
            wrap_req    = 1'b1;
            for (int c = 0; c <= max_of(int'(period_len), half_mode); c++) begin
                if ($urandom_range(0, 5) == 0) vr_next = ~vr_next;
                step();
            end
        end

        // R11: mid-run reset clears outputs
        rst = 1; step(); step();
        check("R11 irq_a after reset", int'(irq_a), 0);
        check("R11 irq_b after reset", int'(irq_b), 0);
        finish_run();
    end
endmodule